// File: doc/BRIEF.md
# Pipeline halt, break and redirect controller

This block owns the run/stop state of a five-stage in-order pipeline (fetch, register read, execute, data, writeback). It keeps a valid bit, a break tag and a PC for every stage, and it advances the fetch PC. It decides, cycle by cycle, whether the pipeline moves, which stages lose their instruction, and where fetch restarts. Three sources can change that state: a host write of a new program counter, host commands that set or clear the status flags, and a BREAK instruction reaching the data stage.

A BREAK stops the machine at the boundary where it leaves the data stage for the writeback latch. The instruction ahead of it, in writeback, still completes in that cycle. The BREAK and everything behind it are discarded, and the cycle that follows is aborted. The PC of the instruction in the execute stage, which is the next one in program order, is kept as the resume point. BREAK-driven flag changes go through the same set/clear status path that host commands use. Host commands can also hold the pipeline with its contents frozen and release it later, with nothing lost or repeated.

Top module: `hbk_ctrl`

## Requirements
- R1: After reset the halt flag is 1, the broke flag and the interrupt-on-break enable are 0, all stage valid bits are 0, and the fetch PC and the resume PC are 0.
- R2: While the halt flag is 1, `abort` is high, no retire is reported, and the stage valid bits and the fetch PC hold their values unless a PC write occurs.
- R3: In a running cycle the instruction at the fetch PC enters the fetch stage and the fetch PC increments by one. Instructions retire in program order. An instruction latched into fetch at an edge shows `retire_vld` with its PC in the fifth cycle after that edge.
- R4: A PC write flushes all five stages in the cycle it is asserted (`flush` = 5'b11111), with no retire in that cycle. From the next cycle, the fetch PC equals the written value and every stage valid bit is 0. This holds whether the processor is running or halted.
- R5: A BREAK fires when a valid BREAK-tagged instruction is in the data stage during a running cycle with no PC write. At that edge halt and broke become 1, the fetch, read, execute and data stages are flushed (`flush` = 5'b01111), and the writeback instruction retires normally.
- R6: On a BREAK, the resume PC and the fetch PC both take the PC held in the execute stage. The fetch PC is never used as the resume point.
- R7: Host command word bits: bit 0 clears halt, bit 1 sets halt, bit 2 clears broke, bit 3 clears the interrupt-on-break enable, bit 4 sets it. Bit 31 is the internal set-broke command and is ignored when it comes from the host. When a set and a clear of the same flag arrive together, the set wins.
- R8: When a BREAK fires with the interrupt-on-break enable at 1, `brk_irq` is high for exactly the one cycle after the firing edge. With the enable at 0 it stays low.
- R9: A host halt followed by a host unhalt resumes the frozen pipeline, so no instruction is skipped or retired twice.
- R10: After a BREAK the pipeline is empty. When halt is cleared, fetch starts at the resume PC, and that PC is the first to retire, in the sixth cycle after the clearing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_wr_en | input | 1 | Host write of the program counter |
| pc_wr_data | input | PC_W | New program counter value |
| cmd_wr_en | input | 1 | Host status command strobe |
| cmd_wr_data | input | 32 | Host set/clear command word |
| fetch_brk | input | 1 | Instruction at `fetch_pc` is a BREAK |
| fetch_pc | output | PC_W | Address being fetched this cycle |
| stage_vld | output | 5 | Valid bits, bit 0 fetch up to bit 4 writeback |
| flush | output | 5 | Per-stage discard in this cycle |
| abort | output | 1 | Current cycle is aborted (no stage advances) |
| retire_vld | output | 1 | Writeback instruction completes this cycle |
| retire_pc | output | PC_W | PC of the completing instruction |
| resume_pc | output | PC_W | Restart address stored by the last BREAK |
| halted | output | 1 | Halt status flag |
| broke | output | 1 | Broke status flag |
| brk_irq_en | output | 1 | Interrupt-on-break enable flag |
| brk_irq | output | 1 | One-cycle interrupt pulse after a BREAK |

## Verification
A wrong resume point shows up six cycles after an unhalt: the first retired PC is the fetch-side address or a skipped one instead of the instruction after the BREAK. A flush that misses a stage lets an instruction from the old address reach `retire_pc` within five cycles of a PC write, even one made while halted and released later. If the halt is taken from a latch one stage too late, one extra instruction retires before `halted` rises. A halt that does not freeze the stages shows as a change in `stage_vld` or `fetch_pc` during the halted window.

// File: rtl/hbk_pkg.sv
package hbk_pkg;
  localparam int NSTG = 5;
  localparam int S_IF = 0;
  localparam int S_RD = 1;
  localparam int S_EX = 2;
  localparam int S_DF = 3;
  localparam int S_WB = 4;

  // command word bit positions
  localparam int C_CLR_HALT  = 0;
  localparam int C_SET_HALT  = 1;
  localparam int C_CLR_BROKE = 2;
  localparam int C_CLR_IEB   = 3;
  localparam int C_SET_IEB   = 4;
  localparam int C_SET_BROKE = 31;  // internal only, stripped from host writes

  localparam logic [31:0] HOST_CMD_MASK = ~(32'd1 << C_SET_BROKE);

  // set has priority over clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  function automatic logic [31:0] brk_cmd_word();
    return (32'd1 << C_SET_HALT) | (32'd1 << C_SET_BROKE);
  endfunction
endpackage

// File: rtl/hbk_status.sv
module hbk_status
  import hbk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_en,
  input  logic [31:0] host_cmd,
  input  logic        brk_set,
  output logic        halt_q,
  output logic        broke_q,
  output logic        ieb_q
);
  logic [31:0] cmd_w;
  logic        unused_cmd;

  assign cmd_w = (host_en ? (host_cmd & HOST_CMD_MASK) : 32'd0) |
                 (brk_set ? brk_cmd_word() : 32'd0);
  assign unused_cmd = ^cmd_w[30:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b1;
      broke_q <= 1'b0;
      ieb_q   <= 1'b0;
    end else begin
      halt_q  <= flag_next(halt_q,  cmd_w[C_SET_HALT],  cmd_w[C_CLR_HALT]);
      broke_q <= flag_next(broke_q, cmd_w[C_SET_BROKE], cmd_w[C_CLR_BROKE]);
      ieb_q   <= flag_next(ieb_q,   cmd_w[C_SET_IEB],   cmd_w[C_CLR_IEB]);
    end
  end

  // R7: broke can only rise through the internal break command
  broke_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(broke_q) |-> $past(brk_set));
endmodule

// File: rtl/hbk_pipe.sv
module hbk_pipe
  import hbk_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            fetch_kill,
  input  logic            redirect_en,
  input  logic [PC_W-1:0] redirect_pc,
  input  logic            fetch_brk,
  input  logic [NSTG-1:0] flush,
  output logic [NSTG-1:0] vld_q,
  output logic            df_brk,
  output logic [PC_W-1:0] ex_pc,
  output logic [PC_W-1:0] wb_pc,
  output logic [PC_W-1:0] fetch_pc_q
);
  logic [PC_W-1:0] pc_a [NSTG];
  logic [S_DF:0]   brk_a;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    logic            in_vld;
    logic [PC_W-1:0] in_pc;
    logic            v_r;
    logic [PC_W-1:0] p_r;

    if (s == 0) begin : g_head
      assign in_vld = ~fetch_kill;
      assign in_pc  = fetch_pc_q;
    end else begin : g_body
      assign in_vld = vld_q[s-1] & ~flush[s-1];
      assign in_pc  = pc_a[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_r <= 1'b0;
        p_r <= '0;
      end else if (adv) begin
        v_r <= in_vld;
        p_r <= in_pc;
      end else if (flush[s]) begin
        v_r <= 1'b0;
      end
    end
    assign vld_q[s] = v_r;
    assign pc_a[s]  = p_r;

    if (s <= S_DF) begin : g_tag
      logic in_brk;
      logic b_r;
      if (s == 0) begin : g_tin
        assign in_brk = fetch_brk;
      end else begin : g_tmid
        assign in_brk = brk_a[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   b_r <= 1'b0;
        else if (adv) b_r <= in_brk;
      end
      assign brk_a[s] = b_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           fetch_pc_q <= '0;
    else if (redirect_en) fetch_pc_q <= redirect_pc;
    else if (adv)         fetch_pc_q <= fetch_pc_q + 1'b1;
  end

  assign df_brk = vld_q[S_DF] & brk_a[S_DF];
  assign ex_pc  = pc_a[S_EX];
  assign wb_pc  = pc_a[S_WB];

  // R2: a frozen cycle without flush or redirect keeps every stage and the fetch PC
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && flush == '0 && !redirect_en) |=> ($stable(vld_q) && $stable(fetch_pc_q)));
endmodule

// File: rtl/hbk_ctrl.sv
module hbk_ctrl
  import hbk_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_wr_en,
  input  logic [PC_W-1:0] pc_wr_data,
  input  logic            cmd_wr_en,
  input  logic [31:0]     cmd_wr_data,
  input  logic            fetch_brk,
  output logic [PC_W-1:0] fetch_pc,
  output logic [NSTG-1:0] stage_vld,
  output logic [NSTG-1:0] flush,
  output logic            abort,
  output logic            retire_vld,
  output logic [PC_W-1:0] retire_pc,
  output logic [PC_W-1:0] resume_pc,
  output logic            halted,
  output logic            broke,
  output logic            brk_irq_en,
  output logic            brk_irq
);
  logic            halt_q;
  logic            df_brk;
  logic            brk_fire;
  logic            redirect_en;
  logic [PC_W-1:0] redirect_pc;
  logic [PC_W-1:0] ex_pc;
  logic [PC_W-1:0] wb_pc;
  logic [PC_W-1:0] resume_q;
  logic            irq_q;

  // break is taken as the tagged instruction moves into the writeback latch
  assign brk_fire    = ~halt_q & df_brk & ~pc_wr_en;
  assign redirect_en = pc_wr_en | brk_fire;
  assign redirect_pc = pc_wr_en ? pc_wr_data : ex_pc;

  for (genvar s = 0; s < NSTG; s++) begin : g_fl
    if (s == S_WB) begin : g_wb
      assign flush[s] = pc_wr_en;
    end else begin : g_up
      assign flush[s] = pc_wr_en | brk_fire;
    end
  end

  hbk_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_en  (cmd_wr_en),
    .host_cmd (cmd_wr_data),
    .brk_set  (brk_fire),
    .halt_q   (halt_q),
    .broke_q  (broke),
    .ieb_q    (brk_irq_en)
  );

  hbk_pipe #(.PC_W(PC_W)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .adv         (~halt_q),
    .fetch_kill  (redirect_en),
    .redirect_en (redirect_en),
    .redirect_pc (redirect_pc),
    .fetch_brk   (fetch_brk),
    .flush       (flush),
    .vld_q       (stage_vld),
    .df_brk      (df_brk),
    .ex_pc       (ex_pc),
    .wb_pc       (wb_pc),
    .fetch_pc_q  (fetch_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (brk_fire) resume_q <= ex_pc;
      irq_q <= brk_fire & brk_irq_en;
    end
  end

  assign resume_pc  = resume_q;
  assign brk_irq    = irq_q;
  assign halted     = halt_q;
  assign abort      = halt_q;
  assign retire_vld = ~halt_q & stage_vld[S_WB] & ~flush[S_WB];
  assign retire_pc  = wb_pc;

  // R4
  pcwr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr_en |=> (stage_vld == '0 && fetch_pc == $past(pc_wr_data)));

  // R5
  brk_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_fire |=> (halted && broke));

  // R6
  resume_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_fire && !cmd_wr_en) |=> (fetch_pc == resume_pc && stage_vld == '0));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |=> !brk_irq);
endmodule

// File: tb/hbk_ctrl_tb.sv
`timescale 1ns/1ps
module hbk_ctrl_tb;
  localparam int PC_W = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pc_wr_en = 1'b0;
  logic [PC_W-1:0] pc_wr_data = '0;
  logic            cmd_wr_en = 1'b0;
  logic [31:0]     cmd_wr_data = '0;
  logic            fetch_brk;
  logic [PC_W-1:0] fetch_pc;
  logic [4:0]      stage_vld;
  logic [4:0]      flush;
  logic            abort, retire_vld, halted, broke, brk_irq_en, brk_irq;
  logic [PC_W-1:0] retire_pc, resume_pc;

  logic            brk_on = 1'b0;
  logic [PC_W-1:0] brk_pc = '0;
  logic [PC_W-1:0] exp_q[$];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // instruction memory model: one BREAK at brk_pc
  assign fetch_brk = brk_on && (fetch_pc == brk_pc);

  hbk_ctrl #(.PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
    .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data), .fetch_brk(fetch_brk),
    .fetch_pc(fetch_pc), .stage_vld(stage_vld), .flush(flush), .abort(abort),
    .retire_vld(retire_vld), .retire_pc(retire_pc), .resume_pc(resume_pc),
    .halted(halted), .broke(broke), .brk_irq_en(brk_irq_en), .brk_irq(brk_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push_range(input int first, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(PC_W'(first + i));
  endtask

  task automatic host_cmd(input logic [31:0] w);
    cmd_wr_en = 1'b1;
    cmd_wr_data = w;
    tick();
    cmd_wr_en = 1'b0;
    cmd_wr_data = '0;
  endtask

  task automatic pc_write(input int v);
    pc_wr_en = 1'b1;
    pc_wr_data = PC_W'(v);
    exp_q.delete();
    #0.5;
    chk(flush == 5'b11111, "R4 flush on pc write", 32'(flush), 32'h1f);
    chk(retire_vld == 1'b0, "R4 retire suppressed", 32'(retire_vld), 0);
    tick();
    pc_wr_en = 1'b0;
    chk(fetch_pc == PC_W'(v), "R4 fetch pc after write", 32'(fetch_pc), v);
    chk(stage_vld == '0, "R4 stages empty after write", 32'(stage_vld), 0);
  endtask

  task automatic wait_halt();
    for (int i = 0; i < 200 && !halted; i++) tick();
    chk(halted == 1'b1, "R5 halt after break", 32'(halted), 1);
  endtask

  // scoreboard monitor: compares every retire with the expected program order
  always @(negedge clk) begin
    if (rst_n && retire_vld) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected retire", 32'(retire_pc), 0);
      else begin
        logic [PC_W-1:0] e;
        e = exp_q.pop_front();
        chk(retire_pc == e, "R3 retire order", 32'(retire_pc), 32'(e));
      end
    end
  end

  initial begin
    logic [4:0]      sv;
    logic [PC_W-1:0] fp;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk(halted == 1'b1, "R1 halted", 32'(halted), 1);
    chk(abort == 1'b1, "R1 abort", 32'(abort), 1);
    chk(broke == 1'b0, "R1 broke", 32'(broke), 0);
    chk(brk_irq_en == 1'b0, "R1 irq enable", 32'(brk_irq_en), 0);
    chk(stage_vld == '0, "R1 stage valids", 32'(stage_vld), 0);
    chk(fetch_pc == '0, "R1 fetch pc", 32'(fetch_pc), 0);
    chk(resume_pc == '0, "R1 resume pc", 32'(resume_pc), 0);

    // R7 host bit 31 ignored; set wins over clear
    host_cmd(32'h8000_0000);
    chk(broke == 1'b0, "R7 host set-broke ignored", 32'(broke), 0);
    host_cmd(32'h0000_0003);
    chk(halted == 1'b1, "R7 set wins", 32'(halted), 1);

    // segment A: write pc while halted, run, host halt/unhalt, break at 26
    brk_on = 1'b1;
    brk_pc = 12'd26;
    pc_write(16);
    push_range(16, 10);
    host_cmd(32'h1);
    repeat (8) tick();
    host_cmd(32'h2);
    chk(halted == 1'b1, "R2 host halt", 32'(halted), 1);
    sv = stage_vld;
    fp = fetch_pc;
    repeat (4) tick();
    chk(stage_vld == sv, "R2 stages frozen", 32'(stage_vld), 32'(sv));
    chk(fetch_pc == fp, "R2 fetch pc frozen", 32'(fetch_pc), 32'(fp));
    chk(abort == 1'b1, "R2 abort while halted", 32'(abort), 1);
    host_cmd(32'h1);
    wait_halt();
    chk(broke == 1'b1, "R5 broke set", 32'(broke), 1);
    chk(resume_pc == 12'd27, "R6 resume pc", 32'(resume_pc), 27);
    chk(fetch_pc == 12'd27, "R6 fetch at resume", 32'(fetch_pc), 27);
    chk(stage_vld == '0, "R10 pipeline empty", 32'(stage_vld), 0);
    chk(brk_irq == 1'b0, "R8 no irq when disabled", 32'(brk_irq), 0);
    chk(exp_q.size() == 0, "R9 all retired once", exp_q.size(), 0);

    // segment B: unhalt + clear broke + enable irq, break at 33
    brk_pc = 12'd33;
    push_range(27, 6);
    host_cmd(32'h15);
    chk(broke == 1'b0 && brk_irq_en == 1'b1 && halted == 1'b0, "R7 combined command",
        {29'd0, broke, brk_irq_en, halted}, 32'h2);
    repeat (5) tick();
    chk(retire_vld && retire_pc == 12'd27, "R10 first retire latency", 32'(retire_pc), 27);
    wait_halt();
    chk(brk_irq == 1'b1, "R8 irq pulse", 32'(brk_irq), 1);
    chk(resume_pc == 12'd34, "R6 resume pc B", 32'(resume_pc), 34);
    tick();
    chk(brk_irq == 1'b0, "R8 irq one cycle", 32'(brk_irq), 0);
    chk(exp_q.size() == 0, "R3 segment B drained", exp_q.size(), 0);

    // segment C: pc write while running, break at 90
    brk_pc = 12'd90;
    host_cmd(32'h1);
    repeat (3) tick();
    pc_write(80);
    push_range(80, 10);
    repeat (7) tick();
    host_cmd(32'h3);
    chk(halted == 1'b1, "R7 set wins while running", 32'(halted), 1);
    host_cmd(32'h1);
    wait_halt();
    chk(resume_pc == 12'd91, "R6 resume pc C", 32'(resume_pc), 91);
    chk(brk_irq == 1'b1, "R8 irq pulse C", 32'(brk_irq), 1);
    chk(exp_q.size() == 0, "R4 segment C drained", exp_q.size(), 0);

    // segment D: halt with full pipeline, pc write while halted discards it
    brk_pc = 12'd120;
    host_cmd(32'h1);
    repeat (2) tick();
    host_cmd(32'h2);
    chk(stage_vld != '0, "R2 pipeline holds work", 32'(stage_vld), 32'h7);
    pc_write(100);
    push_range(100, 20);
    host_cmd(32'h1);
    wait_halt();
    chk(resume_pc == 12'd121, "R6 resume pc D", 32'(resume_pc), 121);
    chk(exp_q.size() == 0, "R4 old work never retired", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule